// File: doc/BRIEF.md
# DDR Read Burst Sequencer

This block follows a READ command on a double data rate memory device and works out, half clock by half clock, which column each data beat belongs to and when the data-valid window opens and closes. Two beats fit in every clock: one in the rising half and one in the falling half. For that reason the block counts time in half-clock slots, and a latency of two and a half clocks is an ordinary slot count, not a special case. Each clock it presents a rising-half lane and a falling-half lane. Each lane carries a column index, a valid flag and a done flag.

The burst length, the ordering type and the latency are sampled from configuration inputs when the READ is accepted and are held for the rest of that burst. A precharge aimed at the bank being read cuts the burst short, and so does a precharge that covers all banks. A READ that carries the auto-precharge flag raises a one-clock request naming its bank in the same clock as the done flag. A second READ that arrives while a burst is running drops what is left of the first burst and starts over from its own column.

Top module: `ddr_rd_burst_seq`

## Requirements
- R1: While reset is high and in the clock after it, every lane valid, lane done and auto-precharge request output is low.
- R2: Slot 2m is the rising half and slot 2m+1 is the falling half of the clock that follows the m-th rising edge after the READ edge (m=0 is the READ edge). The first beat falls in slot 4 when `cfg_cl_half_i`=0 (latency 2) and in slot 5 when it is 1 (latency 2.5). Valid is then high for exactly burst-length consecutive slots.
- R3: `cfg_bl_i` encodes the burst length: 0 gives 2 beats, 1 gives 4 beats, 2 and 3 give 8 beats.
- R4: With `cfg_ilv_i`=0 (sequential), beat i carries low column bits (s+i) mod BL, where s is the starting column's low bits within the BL-aligned block.
- R5: With `cfg_ilv_i`=1 (interleaved), beat i carries low column bits s XOR i.
- R6: Column bits above the burst-length block are the starting column's bits, unchanged for every beat.
- R7: Exactly one done flag is raised, in the slot right after the last valid beat, and no valid beat follows it until the next READ.
- R8: A precharge (`cmd_i`=2) to the bank being read, or one with `cmd_ap_i`=1 to any bank, clears every lane from the outputs registered at that edge onward. No done flag and no auto-precharge request follow.
- R9: A precharge with `cmd_ap_i`=0 to a different bank has no effect on the burst.
- R10: A READ with `cmd_ap_i`=1 raises `ap_req_o` for one clock, in the clock that carries its done flag, with `ap_bank_o` equal to the READ's bank. A READ with `cmd_ap_i`=0 never raises it.
- R11: A READ (`cmd_i`=1) accepted during a burst blanks the outputs at that edge, discards the old beats, done flag and request, and times a new burst from its own edge.
- R12: Changes on the configuration inputs after the READ edge do not alter a burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Command: 0 none, 1 READ, 2 precharge, 3 other (ignored) |
| cmd_bank_i | input | BANK_W | Bank addressed by the command |
| cmd_col_i | input | COL_W | Starting column of a READ |
| cmd_ap_i | input | 1 | Auto-precharge on READ; all-bank on precharge |
| cfg_bl_i | input | 2 | Burst length setting |
| cfg_ilv_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| cfg_cl_half_i | input | 1 | Latency: 0 two clocks, 1 two and a half |
| col_rise_o | output | COL_W | Column of the rising-half beat |
| vld_rise_o | output | 1 | Rising-half beat valid |
| done_rise_o | output | 1 | Rising half is the slot after the final beat |
| col_fall_o | output | COL_W | Column of the falling-half beat |
| vld_fall_o | output | 1 | Falling-half beat valid |
| done_fall_o | output | 1 | Falling half is the slot after the final beat |
| ap_req_o | output | 1 | Auto-precharge request pulse |
| ap_bank_o | output | BANK_W | Bank of the auto-precharge request |

## Verification
The bench focuses on the half-slot shift of latency 2.5. A design that rounds that latency would put the first beat and the done flag in the wrong lane, and the done flag would land in the rising half when it belongs in the falling half. Starting columns near the top of the burst block expose a sequential order that carries into the upper column bits instead of wrapping. They also expose an interleaved order that adds where it should XOR. Precharges aimed at the same bank, at another bank and at all banks check that only matching ones cut the burst and that a cut burst leaves no stray done flag or auto-precharge request. A mid-burst READ and mid-burst configuration changes catch a design that mixes the two bursts or reads its settings live.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;
  localparam int MAX_BL = 8;
  localparam int BEAT_W = $clog2(MAX_BL);
  localparam int CNT_W  = 4;
  localparam int SLOT_W = CNT_W + 1;
  localparam int LANES  = 2;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_PRE   = 2'd2,
    CMD_OTHER = 2'd3
  } rd_cmd_e;

  function automatic logic [SLOT_W-1:0] bl_beats(input logic [1:0] sel);
    case (sel)
      2'd0:    bl_beats = SLOT_W'(2);
      2'd1:    bl_beats = SLOT_W'(4);
      default: bl_beats = SLOT_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/ddr_rd_order.sv
module ddr_rd_order
  import ddr_rd_pkg::*;
(
  input  logic [BEAT_W-1:0] start_low,
  input  logic [BEAT_W-1:0] beat,
  input  logic [BEAT_W-1:0] bl_mask,
  input  logic              ilv,
  output logic [BEAT_W-1:0] col_low
);
  logic [BEAT_W-1:0] step;

  always_comb begin
    if (ilv) step = start_low ^ beat;
    else     step = start_low + beat;
    col_low = (start_low & ~bl_mask) | (step & bl_mask);
  end
endmodule

// File: rtl/ddr_rd_timer.sv
module ddr_rd_timer
  import ddr_rd_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int BANK_W = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [1:0]                   cmd,
  input  logic [BANK_W-1:0]            bank,
  input  logic [COL_W-1:0]             col,
  input  logic                         ap,
  input  logic [1:0]                   bl_sel,
  input  logic                         ilv,
  input  logic                         cl_half,
  output logic [LANES-1:0]             lane_vld,
  output logic [LANES-1:0]             lane_done,
  output logic [LANES-1:0][BEAT_W-1:0] lane_beat,
  output logic [COL_W-1:0]             start_q,
  output logic [BEAT_W-1:0]            bl_mask,
  output logic                         ilv_q,
  output logic [BANK_W-1:0]            bank_q,
  output logic                         ap_fire,
  output logic                         kill
);
  logic              act_q, ap_q;
  logic [CNT_W-1:0]  m_q;
  logic [SLOT_W-1:0] first_q, bl_q, end_q;
  logic              is_read, pre_hit, last_clk;

  assign is_read  = rd_cmd_e'(cmd) == CMD_READ;
  assign pre_hit  = rd_cmd_e'(cmd) == CMD_PRE && act_q && (ap || bank == bank_q);
  assign kill     = is_read || pre_hit;
  assign end_q    = first_q + bl_q;
  assign last_clk = {m_q, 1'b1} >= end_q;
  assign bl_mask  = BEAT_W'(bl_q - SLOT_W'(1));
  assign ap_fire  = ap_q && (|lane_done);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [SLOT_W-1:0] slot;
    assign slot         = {m_q, 1'b0} + SLOT_W'(j);
    assign lane_vld[j]  = act_q && slot >= first_q && slot < end_q;
    assign lane_done[j] = act_q && slot == end_q;
    assign lane_beat[j] = BEAT_W'(slot - first_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      m_q     <= '0;
      first_q <= '0;
      bl_q    <= SLOT_W'(2);
      start_q <= '0;
      ilv_q   <= 1'b0;
      bank_q  <= '0;
      ap_q    <= 1'b0;
    end else if (is_read) begin
      act_q   <= 1'b1;
      m_q     <= CNT_W'(1);
      first_q <= SLOT_W'(4) + SLOT_W'(cl_half);
      bl_q    <= bl_beats(bl_sel);
      start_q <= col;
      ilv_q   <= ilv;
      bank_q  <= bank;
      ap_q    <= ap;
    end else if (pre_hit) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      m_q <= m_q + CNT_W'(1);
      if (last_clk) act_q <= 1'b0;
    end
  end

  assert_slot_bound_R7: assert property (@(posedge clk) disable iff (rst)
    act_q |-> m_q <= CNT_W'(7));
  assert_one_done_lane_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_done));
endmodule

// File: rtl/ddr_rd_burst_seq.sv
module ddr_rd_burst_seq
  import ddr_rd_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cmd_i,
  input  logic [BANK_W-1:0] cmd_bank_i,
  input  logic [COL_W-1:0]  cmd_col_i,
  input  logic              cmd_ap_i,
  input  logic [1:0]        cfg_bl_i,
  input  logic              cfg_ilv_i,
  input  logic              cfg_cl_half_i,
  output logic [COL_W-1:0]  col_rise_o,
  output logic              vld_rise_o,
  output logic              done_rise_o,
  output logic [COL_W-1:0]  col_fall_o,
  output logic              vld_fall_o,
  output logic              done_fall_o,
  output logic              ap_req_o,
  output logic [BANK_W-1:0] ap_bank_o
);
  logic [LANES-1:0]             lane_vld, lane_done;
  logic [LANES-1:0][BEAT_W-1:0] lane_beat, lane_low;
  logic [LANES-1:0][COL_W-1:0]  lane_col;
  logic [COL_W-1:0]             start_q;
  logic [BEAT_W-1:0]            bl_mask;
  logic                         ilv_q, ap_fire, kill;
  logic [BANK_W-1:0]            bank_q;

  ddr_rd_timer #(.COL_W(COL_W), .BANK_W(BANK_W)) timer_i (
    .clk(clk), .rst(rst), .cmd(cmd_i), .bank(cmd_bank_i), .col(cmd_col_i),
    .ap(cmd_ap_i), .bl_sel(cfg_bl_i), .ilv(cfg_ilv_i), .cl_half(cfg_cl_half_i),
    .lane_vld(lane_vld), .lane_done(lane_done), .lane_beat(lane_beat),
    .start_q(start_q), .bl_mask(bl_mask), .ilv_q(ilv_q), .bank_q(bank_q),
    .ap_fire(ap_fire), .kill(kill)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_order
    ddr_rd_order order_i (
      .start_low(start_q[BEAT_W-1:0]), .beat(lane_beat[j]),
      .bl_mask(bl_mask), .ilv(ilv_q), .col_low(lane_low[j])
    );
    assign lane_col[j] = {start_q[COL_W-1:BEAT_W], lane_low[j]};
  end

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      col_rise_o  <= '0;
      col_fall_o  <= '0;
      vld_rise_o  <= 1'b0;
      vld_fall_o  <= 1'b0;
      done_rise_o <= 1'b0;
      done_fall_o <= 1'b0;
      ap_req_o    <= 1'b0;
      ap_bank_o   <= '0;
    end else begin
      col_rise_o  <= lane_col[0];
      col_fall_o  <= lane_col[1];
      vld_rise_o  <= lane_vld[0];
      vld_fall_o  <= lane_vld[1];
      done_rise_o <= lane_done[0];
      done_fall_o <= lane_done[1];
      ap_req_o    <= ap_fire;
      ap_bank_o   <= bank_q;
    end
  end

  assert_done_closes_R7: assert property (@(posedge clk) disable iff (rst)
    (done_rise_o || done_fall_o) |=> !(vld_rise_o || vld_fall_o));
  assert_cut_blank_R8: assert property (@(posedge clk) disable iff (rst)
    kill |=> !(vld_rise_o || vld_fall_o || done_rise_o || done_fall_o || ap_req_o));
  assert_ap_with_done_R10: assert property (@(posedge clk) disable iff (rst)
    ap_req_o |-> (done_rise_o || done_fall_o));
  assert_done_after_beat_R7: assert property (@(posedge clk) disable iff (rst)
    done_fall_o |-> vld_rise_o);
endmodule

// File: tb/ddr_rd_burst_seq_tb_top.sv
module ddr_rd_burst_seq_tb_top;
  localparam int COL_W = 10;
  localparam int BANK_W = 2;
  localparam int NS = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] cmd = 2'd0, bl_sel = 2'd0;
  logic [BANK_W-1:0] bank = '0;
  logic [COL_W-1:0] col = '0;
  logic ap = 1'b0, ilv = 1'b0, clh = 1'b0;
  logic [COL_W-1:0] col_r, col_f;
  logic vld_r, vld_f, dn_r, dn_f, apq;
  logic [BANK_W-1:0] apb;

  always #10 clk = ~clk;

  ddr_rd_burst_seq #(.COL_W(COL_W), .BANK_W(BANK_W)) dut_i (
    .clk(clk), .rst(rst), .cmd_i(cmd), .cmd_bank_i(bank), .cmd_col_i(col),
    .cmd_ap_i(ap), .cfg_bl_i(bl_sel), .cfg_ilv_i(ilv), .cfg_cl_half_i(clh),
    .col_rise_o(col_r), .vld_rise_o(vld_r), .done_rise_o(dn_r),
    .col_fall_o(col_f), .vld_fall_o(vld_f), .done_fall_o(dn_f),
    .ap_req_o(apq), .ap_bank_o(apb)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  bit a_vld [NS], a_done [NS], e_vld [NS], e_done [NS];
  logic [COL_W-1:0] a_col [NS], e_col [NS];
  int a_ap_m, a_ap_cnt, e_ap_m;
  logic [BANK_W-1:0] a_ap_bank, e_ap_bank;

  typedef struct packed {
    logic [COL_W-1:0] start;
    logic [1:0] bl;
    logic il, cl, ap;
    logic [BANK_W-1:0] bank;
    logic [3:0] first;
    logic [4:0] done;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{10'h000, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd4, 5'd6},
    '{10'h005, 2'd1, 1'b0, 1'b1, 1'b1, 2'd1, 4'd5, 5'd9},
    '{10'h00D, 2'd2, 1'b0, 1'b0, 1'b0, 2'd2, 4'd4, 5'd12},
    '{10'h00E, 2'd2, 1'b1, 1'b1, 1'b1, 2'd3, 4'd5, 5'd13},
    '{10'h3F3, 2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 4'd4, 5'd8},
    '{10'h101, 2'd0, 1'b1, 1'b1, 1'b1, 2'd2, 4'd5, 5'd7},
    '{10'h0FF, 2'd3, 1'b0, 1'b0, 1'b1, 2'd1, 4'd4, 5'd12},
    '{10'h212, 2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 4'd4, 5'd8}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int bl_of(input logic [1:0] s);
    return (s == 2'd0) ? 2 : (s == 2'd1) ? 4 : 8;
  endfunction

  function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s,
      input int bl, input bit il, input int i);
    int lo = int'(s) % bl;
    int base = int'(s) - lo;
    int o = il ? (lo ^ i) : ((lo + i) % bl);
    return COL_W'(base + o);
  endfunction

  task automatic clear_exp();
    for (int k = 0; k < NS; k++) begin e_vld[k] = 0; e_done[k] = 0; e_col[k] = '0; end
    e_ap_m = -1; e_ap_bank = '0;
  endtask

  // expected burst from a READ at edge off_m, outputs cut from slot cut onward
  task automatic add_burst(input logic [COL_W-1:0] s, input logic [1:0] bs,
      input bit il, input bit cl, input bit apf, input logic [BANK_W-1:0] bk,
      input int off_m, input int cut);
    int bl = bl_of(bs);
    int f = 2 * off_m + 4 + (cl ? 1 : 0);
    for (int i = 0; i < bl; i++)
      if (f + i < cut && f + i < NS) begin e_vld[f+i] = 1; e_col[f+i] = exp_col(s, bl, il, i); end
    if (f + bl < cut) begin
      e_done[f+bl] = 1;
      if (apf) begin e_ap_m = (f + bl) / 2; e_ap_bank = bk; end
    end
  endtask

  task automatic drive(input logic [1:0] c, input logic [BANK_W-1:0] b,
      input logic [COL_W-1:0] s, input bit a, input logic [1:0] bs, input bit il, input bit cl);
    cmd = c; bank = b; col = s; ap = a; bl_sel = bs; ilv = il; clh = cl;
  endtask

  // READ at edge 0, optional injected command/config at edge inj_m
  task automatic run(input logic [COL_W-1:0] s, input logic [1:0] bs, input bit il,
      input bit cl, input bit apf, input logic [BANK_W-1:0] bk, input int inj_m,
      input logic [1:0] ic, input logic [BANK_W-1:0] ib, input logic [COL_W-1:0] is,
      input bit ia, input logic [1:0] ibs, input bit iil, input bit icl);
    a_ap_m = -1; a_ap_cnt = 0; a_ap_bank = '0;
    @(negedge clk);
    drive(2'd1, bk, s, apf, bs, il, cl);
    for (int m = 0; m < NS / 2; m++) begin
      @(negedge clk);
      a_vld[2*m] = vld_r;   a_col[2*m] = col_r;   a_done[2*m] = dn_r;
      a_vld[2*m+1] = vld_f; a_col[2*m+1] = col_f; a_done[2*m+1] = dn_f;
      if (apq) begin a_ap_m = m; a_ap_bank = apb; a_ap_cnt++; end
      if (m + 1 == inj_m) drive(ic, ib, is, ia, ibs, iil, icl);
      else cmd = 2'd0;
    end
  endtask

  task automatic compare(input string tv, input string tc, input string td, input string ta);
    int bad = -1;
    for (int k = 0; k < NS; k++) if (bad < 0 && a_vld[k] != e_vld[k]) bad = k;
    chk(bad < 0, tv, $sformatf("valid at slot %0d", bad < 0 ? 0 : bad),
        bad < 0 ? 0 : int'(a_vld[bad]), bad < 0 ? 0 : int'(e_vld[bad]));
    bad = -1;
    for (int k = 0; k < NS; k++) if (bad < 0 && e_vld[k] && a_col[k] != e_col[k]) bad = k;
    chk(bad < 0, tc, $sformatf("column at slot %0d", bad < 0 ? 0 : bad),
        bad < 0 ? 0 : int'(a_col[bad]), bad < 0 ? 0 : int'(e_col[bad]));
    bad = -1;
    for (int k = 0; k < NS; k++) if (bad < 0 && a_done[k] != e_done[k]) bad = k;
    chk(bad < 0, td, $sformatf("done at slot %0d", bad < 0 ? 0 : bad),
        bad < 0 ? 0 : int'(a_done[bad]), bad < 0 ? 0 : int'(e_done[bad]));
    chk(a_ap_m == e_ap_m && a_ap_cnt == (e_ap_m >= 0 ? 1 : 0) &&
        (e_ap_m < 0 || a_ap_bank == e_ap_bank), ta, "auto-precharge clock", a_ap_m, e_ap_m);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!vld_r && !vld_f && !dn_r && !dn_f && !apq, "R1", "outputs in reset",
        int'({vld_r, vld_f, dn_r, dn_f, apq}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!vld_r && !vld_f && !dn_r && !dn_f && !apq, "R1", "outputs after reset",
        int'({vld_r, vld_f, dn_r, dn_f, apq}), 0);

    // table walk: R2 R3 timing, R4 R5 R6 order, R7 done, R10 request
    foreach (VEC[v]) begin
      clear_exp();
      chk(bl_of(VEC[v].bl) + VEC[v].first == VEC[v].done &&
          4 + VEC[v].cl == VEC[v].first, "R3", "vector timing", VEC[v].done, 0);
      add_burst(VEC[v].start, VEC[v].bl, VEC[v].il, VEC[v].cl, VEC[v].ap, VEC[v].bank, 0, NS);
      run(VEC[v].start, VEC[v].bl, VEC[v].il, VEC[v].cl, VEC[v].ap, VEC[v].bank,
          0, 2'd0, '0, '0, 1'b0, 2'd0, 1'b0, 1'b0);
      compare("R2 R3", "R4 R5 R6", "R7", "R10");
    end

    // R8: same-bank precharge at edge 3
    clear_exp();
    add_burst(10'h000, 2'd2, 1'b0, 1'b0, 1'b1, 2'd2, 0, 6);
    run(10'h000, 2'd2, 1'b0, 1'b0, 1'b1, 2'd2, 3, 2'd2, 2'd2, '0, 1'b0, 2'd2, 1'b0, 1'b0);
    compare("R8", "R8", "R8", "R8");

    // R8: all-bank precharge to another bank at edge 4
    clear_exp();
    add_burst(10'h003, 2'd2, 1'b1, 1'b1, 1'b1, 2'd1, 0, 8);
    run(10'h003, 2'd2, 1'b1, 1'b1, 1'b1, 2'd1, 4, 2'd2, 2'd3, '0, 1'b1, 2'd2, 1'b1, 1'b1);
    compare("R8", "R8", "R8", "R8");

    // R9: other-bank precharge ignored
    clear_exp();
    add_burst(10'h044, 2'd2, 1'b0, 1'b0, 1'b1, 2'd0, 0, NS);
    run(10'h044, 2'd2, 1'b0, 1'b0, 1'b1, 2'd0, 3, 2'd2, 2'd1, '0, 1'b0, 2'd2, 1'b0, 1'b0);
    compare("R9", "R9", "R9", "R9");

    // R11: READ at edge 3 restarts with its own settings
    clear_exp();
    add_burst(10'h000, 2'd2, 1'b0, 1'b0, 1'b1, 2'd0, 0, 6);
    add_burst(10'h006, 2'd1, 1'b1, 1'b1, 1'b1, 2'd3, 3, NS);
    run(10'h000, 2'd2, 1'b0, 1'b0, 1'b1, 2'd0, 3, 2'd1, 2'd3, 10'h006, 1'b1, 2'd1, 1'b1, 1'b1);
    compare("R11", "R11", "R11", "R11");

    // R12: configuration changes mid-burst are ignored
    clear_exp();
    add_burst(10'h001, 2'd1, 1'b0, 1'b0, 1'b0, 2'd2, 0, NS);
    run(10'h001, 2'd1, 1'b0, 1'b0, 1'b0, 2'd2, 1, 2'd0, 2'd2, 10'h3FF, 1'b1, 2'd2, 1'b1, 1'b1);
    compare("R12", "R12", "R12", "R12");

    // R10: READ without the flag never requests (same bank/timing as vector 2)
    clear_exp();
    add_burst(10'h005, 2'd1, 1'b0, 1'b1, 1'b0, 2'd1, 0, NS);
    run(10'h005, 2'd1, 1'b0, 1'b1, 1'b0, 2'd1, 0, 2'd0, '0, '0, 1'b0, 2'd0, 1'b0, 1'b0);
    compare("R2", "R4", "R7", "R10");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule